// File: doc/BRIEF.md
# Pulse-Gap Tag Receiver and Load-Modulation Responder

This block is the tag side of a low-frequency reader link. The reader sends data by switching its field off for short gaps. The block receives one tick per carrier period and a thresholded field-present level. It counts carrier periods between successive rising edges of the field. It classifies each interval as a data bit, as noise to skip, or as the end of a command. Decoded bits are collected in an 80-bit store, with the first bit in the top position.

Once a command has ended, the block holds the collected bits and their count on its outputs and raises a ready flag. Command logic outside the block then supplies one reply, made of a payload, a payload length and a frame delay time. The block waits until the frame delay, less a guard of eight periods, has passed since the last reader edge. It then loads and unloads the antenna coil in a Manchester pattern: five start ones come first, then the payload. When the last bit is done, the coil is open again and the block listens for the next command with an empty store.

Top module: `pgap_tag_xcvr`

## Requirements
- R1: After reset, coil_load is 0, frame_ready is 0 and frame_bits is 0.
- R2: A rising edge that comes fewer than 15 carrier ticks after the previous rising edge adds no bit, but the interval count still restarts from that edge.
- R3: A rising edge 15 to 23 ticks after the previous rising edge stores a 0 bit.
- R4: A rising edge 24 to 40 ticks after the previous rising edge stores a 1 bit.
- R5: The first rising edge after reset, after an end of command and after a finished reply adds no bit, whatever its interval.
- R6: When the interval count passes 40 ticks with no rising edge, the command ends. If at least one bit is stored, frame_ready rises two clocks after the tick that made the count 41. If no bit is stored, frame_ready stays 0.
- R7: The k-th stored bit (k from 0) is placed at frame_data[79-k]. frame_bits stops at 80, and any later bits are dropped.
- R8: rsp_valid is sampled only while frame_ready is 1. It latches rsp_fdt, rsp_len (0 to 80) and rsp_data, and frame_ready is 0 from the next cycle on.
- R9: The reply starts on the tick that brings the count since the last reader rising edge to rsp_fdt-8. If that count has already been passed when the reply is accepted, the reply starts on the first tick after acceptance.
- R10: A reply is five 1 bits followed by rsp_len payload bits, taken from rsp_data[79] downward.
- R11: Each reply bit lasts 31 ticks. A 1 drives coil_load=1 (coil shorted) for the first 15 ticks and 0 for the other 16. A 0 is the inverse.
- R12: coil_load is 0 at all times outside a reply, including from the tick that ends the last reply bit.
- R13: From the end of a command until the last reply bit is done, rising edges on field_in have no effect on the stored bits or on the reply timing. When the reply completes, frame_bits returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse per carrier period |
| field_in | input | 1 | Thresholded reader field, 1 = field present |
| frame_ready | output | 1 | A command is held and a reply is awaited |
| frame_bits | output | 7 | Number of stored command bits (0 to 80) |
| frame_data | output | 80 | Stored command bits, first bit at bit 79 |
| rsp_valid | input | 1 | Reply offered, taken while frame_ready is 1 |
| rsp_len | input | 7 | Reply payload length in bits (0 to 80) |
| rsp_data | input | 80 | Reply payload, first bit at bit 79 |
| rsp_fdt | input | 9 | Frame delay time in carrier periods (at least 9) |
| coil_load | output | 1 | 1 = coil shorted (loaded), 0 = coil open |

## Verification
A stored bit is counted at the clock edge that sees the rising edge. In the bench, reader edges always fall halfway between two ticks, so an interval of n ticks spans exactly 4n clocks. Each frame_ready rise is measured in clocks from the last reader edge and must come exactly 164 clocks later. The first coil load is due 4·(fdt−8)−1 clocks after that edge, or four clocks after acceptance for a late reply. From there every 31-tick bit is checked one clock into each tick slot, so each slot sample falls well inside its four-clock window. Coil release and the clearing of frame_bits are checked on the exact clock at the end of the last slot.

// File: rtl/pgap_pkg.sv
package pgap_pkg;
  typedef enum logic [1:0] {
    PH_LISTEN,
    PH_HOLD,
    PH_WAIT,
    PH_SEND
  } phase_e;
endpackage

// File: rtl/pgap_interval_meter.sv
module pgap_interval_meter #(
  parameter int CNT_W    = 10,
  parameter int ZERO_MIN = 15,
  parameter int ONE_MIN  = 24,
  parameter int EOF_LIM  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             field_in,
  input  logic             listen,
  input  logic             resync,
  output logic [CNT_W-1:0] since_rise,
  output logic             sym_stb,
  output logic             sym_val,
  output logic             eof_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ZMIN    = CNT_W'(ZERO_MIN);
  localparam logic [CNT_W-1:0] OMIN    = CNT_W'(ONE_MIN);
  localparam logic [CNT_W-1:0] ELIM    = CNT_W'(EOF_LIM);

  logic             field_q;
  logic             stale_q, stale_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise;

  always_comb begin
    rise    = listen & field_in & ~field_q;
    cnt_d   = cnt_q;
    stale_d = stale_q;
    sym_stb = 1'b0;
    sym_val = 1'b0;
    eof_stb = 1'b0;
    if (rise) begin
      cnt_d   = '0;
      stale_d = 1'b0;
      sym_stb = !stale_q && (cnt_q >= ZMIN) && (cnt_q <= ELIM);
      sym_val = cnt_q >= OMIN;
    end else begin
      if (tick && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
      if (listen && !stale_q && (cnt_q > ELIM)) begin
        eof_stb = 1'b1;
        stale_d = 1'b1;
      end
    end
    if (resync) stale_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 1'b0;
      stale_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      field_q <= field_in;
      stale_q <= stale_d;
      cnt_q   <= cnt_d;
    end
  end

  assign since_rise = cnt_q;
endmodule

// File: rtl/pgap_rx_pack.sv
module pgap_rx_pack #(
  parameter int MAX_BITS = 80,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_stb,
  input  logic                sym_val,
  input  logic                clear,
  output logic [MAX_BITS-1:0] data,
  output logic [CW-1:0]       count
);
  logic [CW-1:0] count_q, count_d;
  logic          room;

  assign room = count_q < CW'(MAX_BITS);

  always_comb begin
    count_d = count_q;
    if (clear)                count_d = '0;
    else if (sym_stb && room) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_cell
    logic cell_q;
    logic hit;
    assign hit = sym_stb && room && (count_q == CW'(MAX_BITS - 1 - i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cell_q <= 1'b0;
      else if (clear) cell_q <= 1'b0;
      else if (hit)   cell_q <= sym_val;
    end
    assign data[i] = cell_q;
  end

  assign count = count_q;
endmodule

// File: rtl/pgap_manch_tx.sv
module pgap_manch_tx #(
  parameter int MAX_BITS = 80,
  parameter int SOF_BITS = 5,
  parameter int HALF_T   = 15,
  parameter int BIT_T    = 31,
  localparam int LW      = $clog2(MAX_BITS + 1),
  localparam int TW      = $clog2(BIT_T),
  localparam int SW      = $clog2(SOF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic [LW-1:0]       load_len,
  input  logic                go,
  output logic                coil_load,
  output logic                busy,
  output logic                done_stb
);
  logic                busy_q, busy_d;
  logic [MAX_BITS-1:0] shr_q, shr_d;
  logic [LW-1:0]       left_q, left_d;
  logic [SW-1:0]       sof_q, sof_d;
  logic [TW-1:0]       tmr_q, tmr_d;
  logic                cur_bit, last_slot, last_sym;

  assign cur_bit   = (sof_q != '0) ? 1'b1 : shr_q[MAX_BITS-1];
  assign last_slot = tmr_q == TW'(BIT_T - 1);
  assign last_sym  = ((sof_q == SW'(1)) && (left_q == '0)) ||
                     ((sof_q == '0) && (left_q == LW'(1)));

  always_comb begin
    busy_d   = busy_q;
    shr_d    = shr_q;
    left_d   = left_q;
    sof_d    = sof_q;
    tmr_d    = tmr_q;
    done_stb = 1'b0;
    if (load) begin
      shr_d  = load_data;
      left_d = load_len;
    end
    if (go) begin
      busy_d = 1'b1;
      tmr_d  = '0;
      sof_d  = SW'(SOF_BITS);
    end else if (busy_q && tick) begin
      if (last_slot) begin
        tmr_d = '0;
        if (sof_q != '0) begin
          sof_d = sof_q - 1'b1;
        end else begin
          shr_d  = shr_q << 1;
          left_d = left_q - 1'b1;
        end
        if (last_sym) begin
          busy_d   = 1'b0;
          done_stb = 1'b1;
        end
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      shr_q  <= '0;
      left_q <= '0;
      sof_q  <= '0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      shr_q  <= shr_d;
      left_q <= left_d;
      sof_q  <= sof_d;
      tmr_q  <= tmr_d;
    end
  end

  assign coil_load = busy_q & (cur_bit ^ (tmr_q >= TW'(HALF_T)));
  assign busy      = busy_q;
endmodule

// File: rtl/pgap_tag_xcvr.sv
module pgap_tag_xcvr
  import pgap_pkg::*;
#(
  parameter int MAX_BITS = 80,
  parameter int CNT_W    = 10,
  parameter int FDT_W    = 9,
  parameter int ZERO_MIN = 15,
  parameter int ONE_MIN  = 24,
  parameter int EOF_LIM  = 40,
  parameter int GUARD    = 8,
  parameter int SOF_BITS = 5,
  parameter int HALF_T   = 15,
  parameter int BIT_T    = 31,
  localparam int LW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                field_in,
  output logic                frame_ready,
  output logic [LW-1:0]       frame_bits,
  output logic [MAX_BITS-1:0] frame_data,
  input  logic                rsp_valid,
  input  logic [LW-1:0]       rsp_len,
  input  logic [MAX_BITS-1:0] rsp_data,
  input  logic [FDT_W-1:0]    rsp_fdt,
  output logic                coil_load
);
  localparam int CMPW = CNT_W + 1;

  phase_e           st_q, st_d;
  logic [FDT_W-1:0] fdt_q, fdt_d;
  logic [CNT_W-1:0] since_rise;
  logic             sym_stb, sym_val, eof_stb;
  logic             listen, accept, due, go, tx_busy, tx_done, resume;

  assign listen = st_q == PH_LISTEN;
  assign accept = (st_q == PH_HOLD) && rsp_valid;
  assign due    = (CMPW'(since_rise) + CMPW'(GUARD + 1)) >= CMPW'(fdt_q);
  assign go     = (st_q == PH_WAIT) && tick && due;
  assign resume = (st_q == PH_SEND) && tx_done;

  always_comb begin
    st_d  = st_q;
    fdt_d = fdt_q;
    case (st_q)
      PH_LISTEN: if (eof_stb && (frame_bits != '0)) st_d = PH_HOLD;
      PH_HOLD: if (rsp_valid) begin
        st_d  = PH_WAIT;
        fdt_d = rsp_fdt;
      end
      PH_WAIT:   if (go) st_d = PH_SEND;
      PH_SEND:   if (tx_done) st_d = PH_LISTEN;
      default:   st_d = PH_LISTEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_LISTEN;
      fdt_q <= '0;
    end else begin
      st_q  <= st_d;
      fdt_q <= fdt_d;
    end
  end

  pgap_interval_meter #(
    .CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ONE_MIN(ONE_MIN), .EOF_LIM(EOF_LIM)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .field_in(field_in),
    .listen(listen), .resync(resume), .since_rise(since_rise),
    .sym_stb(sym_stb), .sym_val(sym_val), .eof_stb(eof_stb)
  );

  pgap_rx_pack #(.MAX_BITS(MAX_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_val(sym_val),
    .clear(resume), .data(frame_data), .count(frame_bits)
  );

  pgap_manch_tx #(
    .MAX_BITS(MAX_BITS), .SOF_BITS(SOF_BITS), .HALF_T(HALF_T), .BIT_T(BIT_T)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(accept),
    .load_data(rsp_data), .load_len(rsp_len), .go(go),
    .coil_load(coil_load), .busy(tx_busy), .done_stb(tx_done)
  );

  assign frame_ready = st_q == PH_HOLD;
endmodule

// File: rtl/pgap_tag_xcvr_chk.sv
module pgap_tag_xcvr_chk #(
  parameter int MAX_BITS = 80,
  parameter int LW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          rsp_valid,
  input logic          frame_ready,
  input logic [LW-1:0] frame_bits,
  input logic          coil_load,
  input logic          tx_busy
);
  // R6
  ready_has_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ready) |-> (frame_bits != '0));

  // R7
  bits_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bits <= LW'(MAX_BITS));

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && rsp_valid) |=> !frame_ready);

  // R9
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tick));

  // R10
  sof_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> coil_load);

  // R11
  coil_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coil_load) |-> $past(tick));

  // R12
  hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> !coil_load);

  // R13
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> $stable(frame_bits));

  // R13
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> (frame_bits == '0));
endmodule

bind pgap_tag_xcvr pgap_tag_xcvr_chk #(.MAX_BITS(MAX_BITS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rsp_valid(rsp_valid),
  .frame_ready(frame_ready), .frame_bits(frame_bits),
  .coil_load(coil_load), .tx_busy(tx_busy)
);

// File: tb/pgap_tag_xcvr_tb.sv
module pgap_tag_xcvr_tb;
  localparam int MAXB = 80;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic            field_in = 1'b0;
  logic            frame_ready;
  logic [6:0]      frame_bits;
  logic [MAXB-1:0] frame_data;
  logic            rsp_valid = 1'b0;
  logic [6:0]      rsp_len = '0;
  logic [MAXB-1:0] rsp_data = '0;
  logic [8:0]      rsp_fdt = '0;
  logic            coil_load;

  int total = 0, bad = 0, cyc = 0, phase = 0, rise_cyc = 0, exp_cnt = 0;
  bit finished = 1'b0;
  logic [MAXB-1:0] exp_data = '0;

  always #2 clk = ~clk;

  pgap_tag_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .field_in(field_in),
    .frame_ready(frame_ready), .frame_bits(frame_bits), .frame_data(frame_data),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .rsp_fdt(rsp_fdt), .coil_load(coil_load)
  );

  task automatic clk1();
    @(negedge clk);
    cyc++;
    phase = (phase + 1) % 4;
    tick = (phase == 0);
  endtask

  task automatic check(string tag, string what, logic [MAXB-1:0] act, logic [MAXB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_gap(int n);
    if (n >= 15 && n <= 40 && exp_cnt < MAXB) begin
      exp_data[MAXB-1-exp_cnt] = (n >= 24);
      exp_cnt++;
    end
  endtask

  task automatic sync_rise();
    field_in = 1'b0;
    clk1();
    while (phase != 1) clk1();
    clk1();
    field_in = 1'b1;
    rise_cyc = cyc;
    exp_data = '0;
    exp_cnt = 0;
  endtask

  // one reader interval of n ticks, rise to rise; starts and ends at phase 2
  task automatic gap(int n);
    clk1(); clk1();
    field_in = 1'b0;
    repeat (4 * (n - 1)) clk1();
    clk1(); clk1();
    field_in = 1'b1;
    rise_cyc = cyc;
    model_gap(n);
  endtask

  task automatic wait_frame(string tag);
    int n = 0;
    while (!frame_ready && n < 400) begin
      clk1();
      n++;
    end
    check("R6", "ready latency in clocks", n, 164);
    check(tag, "frame_bits", frame_bits, exp_cnt);
    check(tag, "frame_data", frame_data, exp_data);
  endtask

  task automatic respond(int fdt, int len, logic [MAXB-1:0] d, bit jam, bit late);
    int start, nbits;
    bit b;
    rsp_fdt = fdt[8:0];
    rsp_len = len[6:0];
    rsp_data = d;
    if (late) begin
      while (phase != 0) clk1();
      clk1();
      start = cyc + 4;
    end else begin
      start = rise_cyc + 4 * (fdt - 8) - 1;
    end
    rsp_valid = 1'b1;
    clk1();
    rsp_valid = 1'b0;
    check("R8", "frame_ready after accept", frame_ready, 0);
    while (cyc < start - 1) begin
      clk1();
      if (jam) field_in = (phase == 1);
    end
    check("R9", "coil before start", coil_load, 0);
    clk1();
    if (jam) field_in = (phase == 1);
    check("R9", "coil at start", coil_load, 1);
    nbits = 5 + len;
    for (int j = 0; j < nbits; j++) begin
      bit ok = 1'b1;
      b = (j < 5) ? 1'b1 : d[MAXB-1-(j-5)];
      if (j == nbits - 1) field_in = 1'b0;
      for (int s = 0; s < 31; s++) begin
        while (cyc < start + 4 * (31 * j + s) + 1) begin
          clk1();
          if (jam && j < nbits - 1) field_in = (phase == 1);
        end
        if (coil_load !== ((s < 15) ? b : !b)) ok = 1'b0;
      end
      check((j < 5) ? "R10" : "R11", $sformatf("bit %0d shape", j), ok, 1);
    end
    while (cyc < start + 124 * nbits - 1) clk1();
    check("R11", "last half still driven", coil_load, !b);
    clk1();
    check("R12", "coil open after reply", coil_load, 0);
    check("R13", "store empty after reply", frame_bits, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) clk1();
    rst_n = 1'b1;
    clk1();
    check("R1", "coil after reset", coil_load, 0);
    check("R1", "ready after reset", frame_ready, 0);
    check("R1", "bits after reset", frame_bits, 0);

    // first edge after reset, short interval skipped, then a 0 and a 1
    repeat (80) clk1();
    sync_rise();
    gap(14);
    gap(20);
    gap(30);
    wait_frame("R2 R5");
    respond(208, 12, 80'hA5C0_0000_0000_0000_0000, 1'b1, 1'b0);

    // sweep every interval from 1 to 40 ticks
    sync_rise();
    for (int n = 1; n <= 40; n++) gap(n);
    wait_frame("R3 R4");
    check("R3", "zeros then ones", frame_data[79:54], {9'b0, 17'h1FFFF});
    respond(20, 0, '0, 1'b0, 1'b1);

    // a command of only skipped edges never raises ready
    sync_rise();
    gap(10);
    gap(3);
    repeat (240) clk1();
    check("R6", "no ready without bits", frame_ready, 0);
    check("R2", "no bits stored", frame_bits, 0);

    // more than 80 bits: the store saturates
    sync_rise();
    for (int k = 0; k < 90; k++) gap((k % 3 == 0) ? 30 : 17);
    wait_frame("R7");
    respond(208, 80, 80'h9F31_07C2_E85A_1B64_D3F0, 1'b0, 1'b0);

    // a one-bit command straight after a reply
    sync_rise();
    gap(23);
    wait_frame("R5 R13");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule